// File: doc/BRIEF.md
# Scatter/Gather DMA Channel Controller

This block holds the control state for one DMA channel that runs a scatter/gather transfer. Software writes an 8-bit command byte that can start or stop the transfer. The same byte can also choose how the end of the transfer is announced: a pulse on the end-of-process line, or a pulse on the interrupt line. The block keeps two flags: one says whether a fetched descriptor is waiting in the Base buffer slot, and one says whether the Current slot holds a buffer. While Base is empty, it asks an external descriptor fetcher for the next descriptor. It moves Base into Current whenever Current is free. Each fetched descriptor carries a flag that marks the end of the list.

When the buffer in Current finishes and no further descriptor will follow, the block ends the transfer. It pulses the chosen termination output for one clock. A stop command also ends the transfer at once, and it sets the channel mask. A read-only status byte shows the run state, both slot flags, the terminated flag, the end-of-list flag and the termination choice.

Top module: `sg_chan_ctrl`

## Requirements
- R1: The command field is write-data bits [1:0]. Value 01 starts a transfer, value 10 stops it, and values 00 and 11 change nothing in the transfer state.
- R2: Write-data bit 7 is stored as the termination choice (1 = end-of-process line, 0 = interrupt line) only when bit 6 of the same write is 1. This holds for every command value. Otherwise, including on a start, the stored choice is unchanged.
- R3: After reset or a master clear, the status byte reads 00h, the stored choice is end-of-process, and the mask, prefetch request and both termination outputs are low.
- R4: The status byte bits are: bit 0 running, bit 1 Base empty, bit 2 Current empty, bit 3 terminated, bit 4 end-of-list seen, bit 7 set when the interrupt line is the chosen termination. Bits 5 and 6 read 0.
- R5: One clock after a start write, the status shows running, Base empty, Current empty, not terminated and end-of-list clear, and the mask is low. The prefetch request is raised in that same cycle.
- R6: The prefetch request is high only while the channel is running, Base is empty and end-of-list is clear. It is held low in any cycle where DREQ is high.
- R7: A cycle with the prefetch request and its acknowledge both high marks Base full. In the same cycle, the end-of-list flag is loaded from the fetched descriptor's last-entry input.
- R8: Base moves into Current, and Base becomes empty, in the clock after Current is empty while Base is full. It also moves in the clock where the buffer-done strobe arrives while Base is full.
- R9: A buffer-done strobe while running, with Current full, Base empty and end-of-list set, ends the transfer. One clock later, running is clear, terminated is set and Current is empty. The chosen output is high for exactly that one cycle.
- R10: One clock after a stop write, running is clear and terminated and mask are set. No termination output pulses.
- R11: A buffer-done strobe with Base empty and end-of-list clear only empties Current. The channel stays running and waits for the next descriptor, and no termination output pulses.
- R12: A start or stop write takes priority over a buffer-done strobe and over a prefetch acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear, same effect as reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte |
| stat_rdata | output | 8 | Status byte |
| dreq | input | 1 | Channel DMA request; blocks the prefetch request |
| pf_req | output | 1 | Descriptor prefetch request |
| pf_ack | input | 1 | Descriptor delivered into Base |
| pf_last | input | 1 | Delivered descriptor is the list's last entry |
| buf_done | input | 1 | Current buffer finished |
| chan_mask | output | 1 | Channel mask |
| eop_o | output | 1 | End-of-process termination pulse |
| irq_o | output | 1 | Interrupt termination pulse |

## Verification
The hardest case to reach is the suspended case. Current finishes while Base is still empty and no end-of-list has been seen, so the channel waits. The descriptor that arrives later is then the last one. To get there, the stimulus holds back the acknowledge while DREQ and the done strobe land, and only then delivers a descriptor marked last. The bench also lines up a start write with a done strobe, and a master clear with an active transfer, to check the priority of writes.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      SG_NOP   = 2'b00,
      SG_START = 2'b01,
      SG_STOP  = 2'b10,
      SG_RSVD  = 2'b11
   } sg_cmd_e;

   localparam int ST_RUN   = 0;
   localparam int ST_BEMP  = 1;
   localparam int ST_CEMP  = 2;
   localparam int ST_TERM  = 3;
   localparam int ST_NNULL = 4;
   localparam int ST_ISEL  = 7;
endpackage

// File: rtl/sg_cmd_dec.sv
module sg_cmd_dec #(
   parameter int REG_W      = 8,
   parameter int SEL_EN_BIT = 6,
   parameter int SEL_BIT    = 7
) (
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic             start,
   output logic             stop,
   output logic             sel_we,
   output logic             sel_val
);
   import sg_pkg::*;

   generate
      if (SEL_BIT >= REG_W || SEL_EN_BIT >= REG_W || REG_W < 8)
         $error("sg_cmd_dec: bit positions do not fit the register width");
   endgenerate

   sg_cmd_e cmd;

   always_comb begin
      cmd     = sg_cmd_e'(wdata[1:0]);
      start   = wr && (cmd == SG_START);
      stop    = wr && (cmd == SG_STOP);
      sel_we  = wr && wdata[SEL_EN_BIT];
      sel_val = wdata[SEL_BIT];
   end
endmodule

// File: rtl/sg_buf_ctl.sv
module sg_buf_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic mclr,
   input  logic start,
   input  logic stop,
   input  logic dreq,
   input  logic pf_ack,
   input  logic pf_last,
   input  logic buf_done,
   output logic run,
   output logic base_emp,
   output logic cur_emp,
   output logic term,
   output logic nnull,
   output logic mask,
   output logic pf_req,
   output logic last_done
);
   logic cmd_any;

   always_comb begin
      cmd_any   = start || stop || mclr;
      pf_req    = run && base_emp && !nnull && !dreq;
      last_done = !cmd_any && run && buf_done && !cur_emp && base_emp && nnull;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0; base_emp <= 1'b0; cur_emp <= 1'b0;
         term <= 1'b0; nnull <= 1'b0; mask <= 1'b0;
      end else if (mclr) begin
         run <= 1'b0; base_emp <= 1'b0; cur_emp <= 1'b0;
         term <= 1'b0; nnull <= 1'b0; mask <= 1'b0;
      end else if (start) begin
         run <= 1'b1; base_emp <= 1'b1; cur_emp <= 1'b1;
         term <= 1'b0; nnull <= 1'b0; mask <= 1'b0;
      end else if (stop) begin
         run  <= 1'b0;
         term <= 1'b1;
         mask <= 1'b1;
      end else if (run) begin
         if (buf_done && !cur_emp) begin
            if (!base_emp) begin
               base_emp <= 1'b1;
            end else if (nnull) begin
               run     <= 1'b0;
               term    <= 1'b1;
               cur_emp <= 1'b1;
            end else begin
               cur_emp <= 1'b1;
            end
         end else if (cur_emp && !base_emp) begin
            cur_emp  <= 1'b0;
            base_emp <= 1'b1;
         end
         if (pf_req && pf_ack) begin
            base_emp <= 1'b0;
            nnull    <= pf_last;
         end
      end
   end

   // R5
   start_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !mclr) |=> (run && base_emp && cur_emp && !term && !nnull && !mask));

   // R10
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start && !mclr) |=> (!run && term && mask));

   // R9
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_done |=> (!run && term && cur_emp));
endmodule

// File: rtl/sg_term_out.sv
module sg_term_out #(
   parameter bit EOP_ACT_HIGH = 1'b1,
   parameter bit IRQ_ACT_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mclr,
   input  logic sel_we,
   input  logic sel_val,
   input  logic last_done,
   output logic irq_sel,
   output logic eop_o,
   output logic irq_o
);
   logic eop_sel, eop_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eop_sel <= 1'b1; eop_q <= 1'b0; irq_q <= 1'b0;
      end else if (mclr) begin
         eop_sel <= 1'b1; eop_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         if (sel_we) eop_sel <= sel_val;
         eop_q <= last_done && eop_sel;
         irq_q <= last_done && !eop_sel;
      end
   end

   assign irq_sel = !eop_sel;

   generate
      if (EOP_ACT_HIGH) begin : g_eop_hi
         assign eop_o = eop_q;
      end else begin : g_eop_lo
         assign eop_o = !eop_q;
      end
      if (IRQ_ACT_HIGH) begin : g_irq_hi
         assign irq_o = irq_q;
      end else begin : g_irq_lo
         assign irq_o = !irq_q;
      end
   endgenerate

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && !mclr) |=> $stable(eop_sel));

   // R9
   last_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_done && !mclr) |=> $countones({eop_q, irq_q}) == 1);

   // R10
   no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last_done |=> !(eop_q || irq_q));
endmodule

// File: rtl/sg_chan_ctrl.sv
module sg_chan_ctrl #(
   parameter int REG_W        = 8,
   parameter bit EOP_ACT_HIGH = 1'b1,
   parameter bit IRQ_ACT_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mclr,
   input  logic             cmd_wr,
   input  logic [REG_W-1:0] cmd_wdata,
   output logic [REG_W-1:0] stat_rdata,
   input  logic             dreq,
   output logic             pf_req,
   input  logic             pf_ack,
   input  logic             pf_last,
   input  logic             buf_done,
   output logic             chan_mask,
   output logic             eop_o,
   output logic             irq_o
);
   import sg_pkg::*;

   generate
      if (REG_W != 8) $error("sg_chan_ctrl: the register byte must be 8 bits");
   endgenerate

   logic start, stop, sel_we, sel_val;
   logic run, base_emp, cur_emp, term, nnull, last_done, irq_sel;

   sg_cmd_dec #(.REG_W(REG_W), .SEL_EN_BIT(6), .SEL_BIT(7)) u_dec (
      .wr(cmd_wr), .wdata(cmd_wdata), .start(start), .stop(stop),
      .sel_we(sel_we), .sel_val(sel_val)
   );

   sg_buf_ctl u_buf (
      .clk(clk), .rst_n(rst_n), .mclr(mclr), .start(start), .stop(stop),
      .dreq(dreq), .pf_ack(pf_ack), .pf_last(pf_last), .buf_done(buf_done),
      .run(run), .base_emp(base_emp), .cur_emp(cur_emp), .term(term),
      .nnull(nnull), .mask(chan_mask), .pf_req(pf_req), .last_done(last_done)
   );

   sg_term_out #(.EOP_ACT_HIGH(EOP_ACT_HIGH), .IRQ_ACT_HIGH(IRQ_ACT_HIGH)) u_term (
      .clk(clk), .rst_n(rst_n), .mclr(mclr), .sel_we(sel_we), .sel_val(sel_val),
      .last_done(last_done), .irq_sel(irq_sel), .eop_o(eop_o), .irq_o(irq_o)
   );

   always_comb begin
      stat_rdata           = '0;
      stat_rdata[ST_RUN]   = run;
      stat_rdata[ST_BEMP]  = base_emp;
      stat_rdata[ST_CEMP]  = cur_emp;
      stat_rdata[ST_TERM]  = term;
      stat_rdata[ST_NNULL] = nnull;
      stat_rdata[ST_ISEL]  = irq_sel;
   end

   // R6
   dreq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> !pf_req);

   // R3
   mclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (stat_rdata == 8'h00 && !chan_mask));
endmodule

// File: tb/tb_sg_chan_ctrl.sv
`timescale 1ns/1ps
module tb_sg_chan_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclr = 1'b0, cmd_wr = 1'b0, dreq = 1'b0;
   logic       pf_ack = 1'b0, pf_last = 1'b0, buf_done = 1'b0;
   logic [7:0] cmd_wdata = 8'h00;
   logic [7:0] stat_rdata;
   logic       pf_req, chan_mask, eop_o, irq_o;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_run, m_be, m_ce, m_term, m_nn, m_mask, m_eopsel = 1'b1, m_eop, m_irq;

   always #2.5 clk = ~clk;

   sg_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mclr(mclr), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .stat_rdata(stat_rdata), .dreq(dreq), .pf_req(pf_req), .pf_ack(pf_ack),
      .pf_last(pf_last), .buf_done(buf_done), .chan_mask(chan_mask),
      .eop_o(eop_o), .irq_o(irq_o)
   );

   function automatic bit m_pf();
      return m_run && m_be && !m_nn && !dreq;
   endfunction

   task automatic cmp(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   task automatic compare();
      int st;
      st = {!m_eopsel, 2'b00, m_nn, m_term, m_ce, m_be, m_run};
      cmp("R4 status", stat_rdata, st);
      cmp("R6 prefetch", pf_req, m_pf());
      cmp("R10 mask", chan_mask, m_mask);
      cmp("R9 eop", eop_o, m_eop);
      cmp("R9 irq", irq_o, m_irq);
   endtask

   task automatic model_clock();
      bit st, sp, last, pf;
      st   = cmd_wr && cmd_wdata[1:0] == 2'b01;
      sp   = cmd_wr && cmd_wdata[1:0] == 2'b10;
      pf   = m_pf();
      last = !(st || sp || mclr) && m_run && buf_done && !m_ce && m_be && m_nn;
      if (mclr) begin
         {m_run, m_be, m_ce, m_term, m_nn, m_mask, m_eop, m_irq} = '0;
         m_eopsel = 1'b1;
         return;
      end
      m_eop = last && m_eopsel;
      m_irq = last && !m_eopsel;
      if (cmd_wr && cmd_wdata[6]) m_eopsel = cmd_wdata[7];
      if (st) begin
         m_run = 1; m_be = 1; m_ce = 1; m_term = 0; m_nn = 0; m_mask = 0;
      end else if (sp) begin
         m_run = 0; m_term = 1; m_mask = 1;
      end else if (m_run) begin
         if (last) begin
            m_run = 0; m_term = 1; m_ce = 1;
         end else if (buf_done && !m_ce) begin
            if (!m_be) m_be = 1;
            else m_ce = 1;
         end else if (m_ce && !m_be) begin
            m_ce = 0; m_be = 1;
         end
         if (pf && pf_ack) begin
            m_be = 0; m_nn = pf_last;
         end
      end
   endtask

   // one clock: drive inputs after the falling edge, check, then advance model
   task automatic step(input bit wr, input logic [7:0] d, input bit dr,
                       input bit ack, input bit lst, input bit done, input bit mc);
      @(negedge clk);
      cmd_wr = wr; cmd_wdata = d; dreq = dr; pf_ack = ack; pf_last = lst;
      buf_done = done; mclr = mc;
      #1;
      compare();
      @(posedge clk);
      model_clock();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #100000;
      fails++;
      $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R3: reset state
      #1; compare();
      rst_n = 1'b1;
      idle(1);
      // R2: select interrupt with NOP field, then hold with enable low, reserved field
      step(1, 8'h40, 0, 0, 0, 0, 0);
      step(1, 8'h80, 0, 0, 0, 0, 0);
      step(1, 8'h03, 0, 0, 0, 0, 0);   // R1 reserved command ignored
      step(1, 8'hC0, 0, 0, 0, 0, 0);   // back to end-of-process
      idle(1);
      // R5 start, R6 DREQ blocks prefetch
      step(1, 8'h01, 0, 0, 0, 0, 0);
      step(0, 8'h00, 1, 1, 0, 0, 0);   // ack ignored while DREQ high
      step(0, 8'h00, 0, 1, 0, 0, 0);   // R7 fill Base
      step(0, 8'h00, 0, 0, 0, 0, 0);   // R8 move to Current
      step(0, 8'h00, 0, 1, 0, 0, 0);   // refill Base
      step(1, 8'h03, 0, 0, 0, 0, 0);   // R1 reserved command while running
      step(0, 8'h00, 0, 0, 0, 1, 0);   // R8 done with Base full
      step(0, 8'h00, 0, 1, 1, 0, 0);   // last descriptor
      step(0, 8'h00, 0, 0, 0, 1, 0);
      idle(1);
      step(0, 8'h00, 0, 0, 0, 1, 0);   // R9 final completion -> end-of-process
      idle(2);
      // R9 interrupt variant, start does not alter choice (R2)
      step(1, 8'h40, 0, 0, 0, 0, 0);
      step(1, 8'h81, 0, 0, 0, 0, 0);
      step(0, 8'h00, 0, 1, 1, 0, 0);
      idle(1);
      step(0, 8'h00, 0, 0, 0, 1, 0);
      idle(2);
      // R11 suspended: Current finishes with Base empty, then last buffer arrives
      step(1, 8'hC1, 0, 0, 0, 0, 0);
      step(0, 8'h00, 0, 1, 0, 0, 0);
      step(0, 8'h00, 1, 0, 0, 0, 0);
      step(0, 8'h00, 1, 0, 0, 1, 0);
      idle(1);
      step(0, 8'h00, 0, 1, 1, 0, 0);
      idle(1);
      step(0, 8'h00, 0, 0, 0, 1, 0);
      idle(2);
      // R10 stop mid-transfer, R12 stop beats done/ack
      step(1, 8'h01, 0, 0, 0, 0, 0);
      step(0, 8'h00, 0, 1, 1, 0, 0);
      idle(1);
      step(1, 8'h02, 0, 1, 0, 1, 0);
      idle(2);
      // R12 start together with a done strobe
      step(1, 8'h01, 0, 0, 0, 0, 0);
      step(0, 8'h00, 0, 1, 1, 0, 0);
      idle(1);
      step(1, 8'h01, 0, 0, 0, 1, 0);
      idle(2);
      // R3 master clear while running with interrupt selected
      step(1, 8'h40, 0, 1, 0, 0, 0);
      step(0, 8'h00, 0, 0, 0, 0, 1);
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule